// File: doc/BRIEF.md
# Single-to-Double Register Load Widener

This block turns a 32-bit single-precision word, as it arrives from memory, into the 64-bit double-precision image kept in a floating-point register file. Bit numbering in this brief is MSB-first: bit 0 is the sign, bits 1..8 are the exponent field and bits 9..31 the fraction. In port terms, brief bit k of the input is `in_word[31-k]`, and brief bit k of the output is `out_dword[63-k]`.

Each input falls into exactly one of three classes. A normalized input has an exponent field strictly between 0 and 255. A special input has an exponent field of 255, or bits 1..31 all zero. A subnormal input has an exponent field of 0 and a nonzero fraction.

Normalized and special inputs are widened by splicing bits. Copies of exponent bit 1 fill the three extra exponent positions, inverted for normalized inputs and not inverted for special ones. Subnormal inputs are renormalized into the wider exponent range. A leading-zero count and a single shift do this, so every result appears one clock after its input is accepted.

Top module: `sp_to_dp_widen`

## Requirements
- R1: A normalized input gives output bits 0..1 equal to input bits 0..1, output bits 2, 3 and 4 equal to the inverse of input bit 1, and output bits 5..63 equal to input bits 2..31 followed by 29 zeros. The three input classes are mutually exclusive.
- R2: A special input (exponent field 255, or bits 1..31 all zero) gives the same output as R1, except that output bits 2..4 equal input bit 1, not inverted.
- R3: For a subnormal input, let L be the number of leading zeros of its 23-bit fraction. The 11-bit output exponent field (bits 1..11) is then 896 - L, which lies between 874 and 896.
- R4: For a subnormal input, output bits 12..34 are the fraction shifted left by L+1 places and truncated to 23 bits. Output bits 35..63 are zero.
- R5: Output bit 0 equals input bit 0 for every class.
- R6: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R7: While `in_valid` is low, `out_dword` keeps its value, whatever `in_word` carries.
- R8: Output bits 35..63 are zero for every input.
- R9: While reset is held, and right after it, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Qualifies `in_word` in this cycle |
| in_word | input | 32 | Single-precision word |
| out_valid | output | 1 | Result in `out_dword` is new this cycle |
| out_dword | output | 64 | Double-precision register image |

## Verification
A wrong class decode appears at the ports in the very next cycle after the input is accepted. It shows as the three extra exponent bits taking the wrong polarity, or as a subnormal emerging spliced instead of renormalized. An error in the leading-zero count moves the exponent field by the same amount the fraction is misaligned. The smallest and largest subnormals expose an off-by-one at either end of the count. A stuck enable on the data register shows as `out_dword` changing during cycles with `in_valid` low.

// File: rtl/sp2dp_pkg.sv
package sp2dp_pkg;
  localparam int unsigned SP_W      = 32;
  localparam int unsigned SP_EXP_W  = 8;
  localparam int unsigned SP_FRAC_W = 23;
  localparam int unsigned DP_W      = 64;
  localparam int unsigned DP_EXP_W  = 11;
  localparam int unsigned DP_FRAC_W = 52;
  localparam int unsigned PAD_W     = DP_FRAC_W - SP_FRAC_W;   // 29
  localparam int unsigned SP_BIAS   = 127;
  localparam int unsigned DP_BIAS   = 1023;
  localparam int unsigned SUB_TOP   = DP_BIAS - SP_BIAS;       // 896
  localparam int unsigned LZ_W      = $clog2(SP_FRAC_W + 1);

  typedef struct packed {
    logic norm;
    logic spec;
    logic sub;
  } cls_t;
endpackage

// File: rtl/sp2dp_classify.sv
module sp2dp_classify
  import sp2dp_pkg::*;
(
  input  logic [SP_W-1:0] word_i,
  output cls_t            cls_o
);
  logic [SP_EXP_W-1:0]  exp_f;
  logic [SP_FRAC_W-1:0] frac_f;
  logic                 exp_zero, exp_ones, frac_zero;

  assign exp_f     = word_i[SP_W-2 -: SP_EXP_W];
  assign frac_f    = word_i[SP_FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  always_comb begin
    cls_o.norm = !exp_zero && !exp_ones;
    cls_o.spec = exp_ones || (exp_zero && frac_zero);
    cls_o.sub  = exp_zero && !frac_zero;
  end
endmodule

// File: rtl/sp2dp_lzc.sv
module sp2dp_lzc #(
  parameter int unsigned W  = 23,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec_i,
  output logic [CW-1:0] cnt_o
);
  // Higher set bits overwrite lower ones, so the topmost one wins.
  always_comb begin
    cnt_o = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/sp2dp_format.sv
module sp2dp_format
  import sp2dp_pkg::*;
(
  input  logic [SP_W-1:0] word_i,
  input  cls_t            cls_i,
  input  logic [LZ_W-1:0] lz_i,
  output logic [DP_W-1:0] dword_o
);
  logic                 sgn, e_msb;
  logic [SP_FRAC_W-1:0] frac_f, sub_frac;
  logic [DP_EXP_W-1:0]  sub_exp;
  logic [LZ_W:0]        sh_amt;
  logic [DP_W-1:0]      splice_w, sub_w;

  assign sgn    = word_i[SP_W-1];
  assign e_msb  = word_i[SP_W-2];
  assign frac_f = word_i[SP_FRAC_W-1:0];
  assign sh_amt = {1'b0, lz_i} + 1'b1;

  always_comb begin
    sub_frac = frac_f << sh_amt;
    sub_exp  = DP_EXP_W'(SUB_TOP) - DP_EXP_W'(lz_i);
    sub_w    = {sgn, sub_exp, sub_frac, {PAD_W{1'b0}}};
    splice_w = {sgn, e_msb, {3{e_msb ^ cls_i.norm}},
                word_i[SP_W-3:0], {PAD_W{1'b0}}};
    dword_o  = cls_i.sub ? sub_w : splice_w;
  end
endmodule

// File: rtl/sp_to_dp_widen.sv
module sp_to_dp_widen
  import sp2dp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [SP_W-1:0] in_word,
  output logic            out_valid,
  output logic [DP_W-1:0] out_dword
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  cls_t            cls;
  logic [LZ_W-1:0] lz;
  logic [DP_W-1:0] dword_d, dword_q;
  logic            vld_d, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sp2dp_classify i_classify (.word_i(in_word), .cls_o(cls));
  sp2dp_lzc #(.W(SP_FRAC_W)) i_lzc (.vec_i(in_word[SP_FRAC_W-1:0]), .cnt_o(lz));
  sp2dp_format i_format (.word_i(in_word), .cls_i(cls), .lz_i(lz), .dword_o(dword_d));

  always_comb vld_d = in_valid;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) vld_q <= 1'b0;
    else            vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) dword_q <= dword_d;
  end

  assign out_valid = vld_q;
  assign out_dword = dword_q;

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot({cls.norm, cls.spec, cls.sub})); // R1
  AST_SUB_EXP_RANGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    cls.sub |-> (dword_d[62:52] >= 11'd874 && dword_d[62:52] <= 11'd896)); // R3
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_dword[63] == $past(in_word[31])); // R5
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid); // R6
  AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(out_dword)); // R7
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> out_dword[28:0] == '0); // R8
endmodule

// File: tb/test_sp_to_dp_widen.sv
module test_sp_to_dp_widen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic        out_valid;
  logic [63:0] out_dword;
  int unsigned n_chk = 0, n_bad = 0;
  int unsigned seed;

  always #5 clk = ~clk;

  sp_to_dp_widen i_sp_to_dp_widen (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_word(in_word), .out_valid(out_valid), .out_dword(out_dword));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_w(input logic [31:0] w);
    logic [7:0]  e;
    logic [52:0] sig;
    int          ex;
    e = w[30:23];
    if (e != 8'd0 && e != 8'd255) return {w[31], w[30], {3{~w[30]}}, w[29:0], 29'b0};
    if (e == 8'd255 || w[30:0] == '0) return {w[31], w[30], {3{w[30]}}, w[29:0], 29'b0};
    sig = {1'b0, w[22:0], 29'b0};
    ex  = -126;
    while (!sig[52]) begin
      sig = sig << 1;
      ex--;
    end
    return {w[31], 11'(ex + 1023), sig[51:0]};
  endfunction

  task automatic apply(input logic [31:0] w);
    logic [63:0] exp_v, held;
    logic [7:0]  e;
    string       tag;
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = $urandom(seed);
    exp_v = ref_w(w);
    e = w[30:23];
    chk(out_valid === 1'b1, "R6", {63'b0, out_valid}, 64'd1);
    if (e == 8'd0 && w[22:0] != '0) begin
      chk(out_dword[62:52] === exp_v[62:52], "R3", {53'b0, out_dword[62:52]}, {53'b0, exp_v[62:52]});
      chk(out_dword[51:0] === exp_v[51:0], "R4", out_dword, exp_v);
    end else begin
      tag = (e != 8'd0 && e != 8'd255) ? "R1" : "R2";
      chk(out_dword === exp_v, tag, out_dword, exp_v);
    end
    chk(out_dword[63] === w[31], "R5", {63'b0, out_dword[63]}, {63'b0, w[31]});
    chk(out_dword[28:0] === '0, "R8", out_dword, {out_dword[63:29], 29'b0});
    held = out_dword;
    @(negedge clk);
    chk(out_valid === 1'b0, "R6", {63'b0, out_valid}, 64'd0);
    chk(out_dword === held, "R7", out_dword, held);
  endtask

  initial begin
    seed = 32'd1357;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_word = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9", {63'b0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R9", {63'b0, out_valid}, 64'd0);
    // directed corners
    apply(32'h3F80_0000);  // 1.0, R1
    apply(32'hC0A0_0000);  // -5.0, R1
    apply(32'h7F7F_FFFF);  // largest normal, R1
    apply(32'h0080_0000);  // smallest normal, R1
    apply(32'h0000_0001);  // smallest subnormal, R3 R4
    apply(32'h807F_FFFF);  // largest negative subnormal, R3 R4
    apply(32'h0040_0000);  // subnormal top bit, R3
    apply(32'h0000_0000);  // +0, R2
    apply(32'h8000_0000);  // -0, R2
    apply(32'h7F80_0000);  // +inf, R2
    apply(32'hFF80_0000);  // -inf, R2
    apply(32'h7FC0_1234);  // quiet NaN, R2
    apply(32'h7FA0_0001);  // signalling NaN, R2
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom(seed);
      case (i % 4)
        0: r[30:23] = 8'd0;
        1: r[30:23] = 8'd255;
        default: ;
      endcase
      apply(r);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule